// File: doc/BRIEF.md
# Multi-Block Flash Program Page Buffer

This block sits in front of a flash array built from eight 32-Kbyte blocks, 256 Kbytes in all. It gathers program data into a page buffer that holds one 64-byte page for each block. Every buffered page must lie at the same page offset inside its block, so a single program pulse can write up to 512 bytes at once. The block can also erase any chosen set of blocks in one pulse.

Neither program nor erase may start until a fixed access sequence has been seen on the key port: one key read, a key write of 0x3C and then a key write of 0xC3. A per-block lock input refuses any operation that would touch a locked block. The pulse lasts a programmable number of system clocks. While the pulse runs, normal array reads are blocked and buffer writes are dropped. When the pulse ends a sticky done flag is raised. A finished program also empties the page buffer.

The analog high-voltage path takes the operation type, the block mask and the page offset from the `hv_*` outputs. It fetches the page bytes through the buffer read port.

Top module: `flash_multipage_prog`

## Requirements
- R1: After reset `st_busy`, `st_done`, `st_offset_err`, `st_lock_err`, `st_armed`, `hv_program`, `hv_erase` and `hv_blocks` are all 0.
- R2: A bus write (`bus_valid`=1, `bus_write`=1) decodes `bus_addr[17:15]` as the block, `bus_addr[14:6]` as the page offset and `bus_addr[5:0]` as the byte. An accepted write becomes readable at `pb_rd_data` (selected by `pb_rd_blk`, `pb_rd_byte`) on the next cycle. Bytes not yet written in a loaded page, and all bytes of an unloaded page, read 0xFF.
- R3: The first buffered write into an empty buffer latches the page offset. A later write with a different offset is dropped, leaves the buffer unchanged and sets the sticky `st_offset_err`.
- R4: `st_armed` rises only after three accesses on the key port in this order: a read (`key_write`=0), a write of 0x3C, then a write of 0xC3. Any other write during the sequence returns it to the start. A command given while not armed has no effect.
- R5: An accepted program command raises `hv_program` on the next cycle. At the same time `hv_blocks` shows the mask of loaded pages (bit n = block n) and `hv_offset` shows the shared page offset.
- R6: An accepted erase command raises `hv_erase`, with `hv_blocks` equal to `cmd_erase_mask`.
- R7: A command whose block set overlaps `cfg_lock` is refused: no pulse starts and `st_lock_err` is set. The next accepted command clears `st_lock_err`.
- R8: `st_busy` stays high for exactly `cfg_pulse_len` cycles, with a value of 0 treated as 1. On the edge where it falls, `st_done` rises; `st_done` clears when the next pulse starts.
- R9: While busy, a bus read keeps `arr_rd_en` low, returns 0 on `bus_rdata` and raises `bus_rd_blocked`. When idle the read passes to the array and `arr_rdata` is returned.
- R10: When a program pulse ends, the page buffer is emptied and `st_offset_err` is cleared, so a new offset can be latched.
- R11: Bus writes made while busy are dropped.
- R12: Any command seen while armed and idle, accepted or refused, clears `st_armed`. If program and erase are requested in the same cycle, program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Array access strobe |
| bus_write | input | 1 | 1 = buffer write, 0 = array read |
| bus_addr | input | 18 | Byte address within the 256-Kbyte array |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data (0 when blocked) |
| bus_rd_blocked | output | 1 | Read refused because a pulse is running |
| arr_rd_en | output | 1 | Read enable to the array |
| arr_addr | output | 18 | Address to the array |
| arr_rdata | input | 8 | Data from the array |
| key_valid | input | 1 | Key port access strobe |
| key_write | input | 1 | 1 = key write, 0 = key read |
| key_data | input | 8 | Key write value |
| cmd_program | input | 1 | Program request pulse |
| cmd_erase | input | 1 | Erase request pulse |
| cmd_erase_mask | input | 8 | Blocks to erase |
| cfg_lock | input | 8 | Per-block lock bits |
| cfg_pulse_len | input | 16 | Pulse length in clocks |
| pb_rd_blk | input | 3 | Buffer read block select |
| pb_rd_byte | input | 6 | Buffer read byte select |
| pb_rd_data | output | 8 | Buffer read data |
| hv_program | output | 1 | Program pulse active |
| hv_erase | output | 1 | Erase pulse active |
| hv_blocks | output | 8 | Blocks taking part in the pulse |
| hv_offset | output | 9 | Shared page offset of the pulse |
| st_armed | output | 1 | Unlock sequence complete |
| st_busy | output | 1 | Pulse running |
| st_done | output | 1 | Sticky pulse complete flag |
| st_offset_err | output | 1 | Sticky offset mismatch flag |
| st_lock_err | output | 1 | Last command refused by a lock |

## Verification
The assertions assume that `cfg_lock` holds steady while a pulse runs, since the lock check is made once at launch. The bench changes the lock bits only when `st_busy` is low. They also assume that command and key strobes last one cycle. The bench drives every strobe for one clock, just after a rising edge, and never holds a command across a pulse boundary.

// File: rtl/fmp_pkg.sv
package fmp_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h3C;
  localparam logic [7:0] KEY_SECOND = 8'hC3;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_GOTRD = 2'd1,
    KS_GOTW1 = 2'd2,
    KS_ARMED = 2'd3
  } key_state_e;
endpackage

// File: rtl/fmp_key_seq.sv
module fmp_key_seq
  import fmp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic              key_write,
  input  logic [DATA_W-1:0] key_data,
  input  logic              consume,
  output logic              armed
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (consume) begin
      state_d = KS_IDLE;
    end else if (key_valid) begin
      if (!key_write) begin
        state_d = KS_GOTRD;
      end else begin
        case (state_q)
          KS_GOTRD: state_d = (key_data == KEY_FIRST)  ? KS_GOTW1 : KS_IDLE;
          KS_GOTW1: state_d = (key_data == KEY_SECOND) ? KS_ARMED : KS_IDLE;
          default:  state_d = KS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KS_ARMED);

  assert_arm_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_valid && key_write && key_data == KEY_SECOND));

  assert_consume_disarms_R12: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !armed);
endmodule

// File: rtl/fmp_pulse_timer.sv
module fmp_pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             fin
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len_eff;

  assign len_eff = (len == '0) ? CNT_W'(1) : len;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = len_eff;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign fin  = (cnt_q == CNT_W'(1)) && !load;

  assert_load_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  assert_fin_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);

  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/fmp_page_buf.sv
module fmp_page_buf #(
  parameter int NUM_BLOCKS = 8,
  parameter int PAGE_BYTES = 64,
  parameter int POFF_W     = 9,
  parameter int DATA_W     = 8,
  localparam int BLK_AW    = $clog2(NUM_BLOCKS),
  localparam int BYTE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BLK_AW-1:0]     wr_blk,
  input  logic [POFF_W-1:0]     wr_poff,
  input  logic [BYTE_AW-1:0]    wr_byte,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clr,
  input  logic [BLK_AW-1:0]     rd_blk,
  input  logic [BYTE_AW-1:0]    rd_byte,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_BLOCKS-1:0] mask,
  output logic [POFF_W-1:0]     poff,
  output logic                  reject
);
  logic [NUM_BLOCKS-1:0] mask_q, mask_d;
  logic [POFF_W-1:0]     poff_q, poff_d;
  logic                  accept;
  logic [DATA_W-1:0]     rd_bytes [NUM_BLOCKS];

  assign accept = wr_en && ((mask_q == '0) || (poff_q == wr_poff));
  assign reject = wr_en && !accept;

  always_comb begin
    mask_d = mask_q;
    poff_d = poff_q;
    if (clr) begin
      mask_d = '0;
    end else if (accept) begin
      mask_d[wr_blk] = 1'b1;
      if (mask_q == '0) poff_d = wr_poff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      poff_q <= '0;
    end else begin
      mask_q <= mask_d;
      poff_q <= poff_d;
    end
  end

  for (genvar gb = 0; gb < NUM_BLOCKS; gb++) begin : g_blk
    logic [DATA_W-1:0] page_q [PAGE_BYTES];
    logic              sel;

    assign sel = accept && (wr_blk == BLK_AW'(gb));

    always_ff @(posedge clk) begin
      if (sel) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (wr_byte == BYTE_AW'(i))  page_q[i] <= wr_data;
          else if (!mask_q[gb])        page_q[i] <= '1;
        end
      end
    end

    assign rd_bytes[gb] = mask_q[gb] ? page_q[rd_byte] : '1;
  end

  assign rd_data = rd_bytes[rd_blk];
  assign mask    = mask_q;
  assign poff    = poff_q;

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));

  assert_offset_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '0 && !clr) |=> $stable(poff));

  assert_no_write_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !wr_en);
endmodule

// File: rtl/flash_multipage_prog.sv
module flash_multipage_prog
  import fmp_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_BYTES = 32768,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  localparam int BLK_AW     = $clog2(NUM_BLOCKS),
  localparam int OFF_AW     = $clog2(BLOCK_BYTES),
  localparam int BYTE_AW    = $clog2(PAGE_BYTES),
  localparam int POFF_W     = OFF_AW - BYTE_AW,
  localparam int ADDR_W     = BLK_AW + OFF_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rd_blocked,
  output logic                  arr_rd_en,
  output logic [ADDR_W-1:0]     arr_addr,
  input  logic [DATA_W-1:0]     arr_rdata,
  input  logic                  key_valid,
  input  logic                  key_write,
  input  logic [DATA_W-1:0]     key_data,
  input  logic                  cmd_program,
  input  logic                  cmd_erase,
  input  logic [NUM_BLOCKS-1:0] cmd_erase_mask,
  input  logic [NUM_BLOCKS-1:0] cfg_lock,
  input  logic [CNT_W-1:0]      cfg_pulse_len,
  input  logic [BLK_AW-1:0]     pb_rd_blk,
  input  logic [BYTE_AW-1:0]    pb_rd_byte,
  output logic [DATA_W-1:0]     pb_rd_data,
  output logic                  hv_program,
  output logic                  hv_erase,
  output logic [NUM_BLOCKS-1:0] hv_blocks,
  output logic [POFF_W-1:0]     hv_offset,
  output logic                  st_armed,
  output logic                  st_busy,
  output logic                  st_done,
  output logic                  st_offset_err,
  output logic                  st_lock_err
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                  busy, fin, armed;
  logic                  cmd_seen, lock_hit, start, refuse, buf_wr, buf_rej, buf_clr;
  logic [NUM_BLOCKS-1:0] buf_mask, req_mask;
  logic [POFF_W-1:0]     buf_poff;

  // operation state
  logic                  op_prog_q, op_prog_d;
  logic                  op_erase_q, op_erase_d;
  logic [NUM_BLOCKS-1:0] op_blocks_q, op_blocks_d;
  logic [POFF_W-1:0]     op_poff_q, op_poff_d;
  logic                  done_q, done_d;
  logic                  lerr_q, lerr_d;
  logic                  oerr_q, oerr_d;

  fmp_key_seq #(.DATA_W(DATA_W)) i_key (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .key_valid (key_valid),
    .key_write (key_write),
    .key_data  (key_data),
    .consume   (cmd_seen),
    .armed     (armed)
  );

  fmp_pulse_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (start),
    .len   (cfg_pulse_len),
    .busy  (busy),
    .fin   (fin)
  );

  assign buf_wr  = bus_valid && bus_write && !busy;
  assign buf_clr = fin && op_prog_q;

  fmp_page_buf #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGE_BYTES (PAGE_BYTES),
    .POFF_W     (POFF_W),
    .DATA_W     (DATA_W)
  ) i_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (buf_wr),
    .wr_blk  (bus_addr[ADDR_W-1 -: BLK_AW]),
    .wr_poff (bus_addr[OFF_AW-1 -: POFF_W]),
    .wr_byte (bus_addr[BYTE_AW-1:0]),
    .wr_data (bus_wdata),
    .clr     (buf_clr),
    .rd_blk  (pb_rd_blk),
    .rd_byte (pb_rd_byte),
    .rd_data (pb_rd_data),
    .mask    (buf_mask),
    .poff    (buf_poff),
    .reject  (buf_rej)
  );

  // command acceptance: program has priority over erase
  assign cmd_seen = (cmd_program || cmd_erase) && armed && !busy;
  assign req_mask = cmd_program ? buf_mask : cmd_erase_mask;
  assign lock_hit = |(req_mask & cfg_lock);
  assign start    = cmd_seen && !lock_hit;
  assign refuse   = cmd_seen && lock_hit;

  always_comb begin
    op_prog_d   = op_prog_q;
    op_erase_d  = op_erase_q;
    op_blocks_d = op_blocks_q;
    op_poff_d   = op_poff_q;
    done_d      = done_q;
    lerr_d      = lerr_q;
    oerr_d      = oerr_q;
    if (start) begin
      op_prog_d   = cmd_program;
      op_erase_d  = !cmd_program;
      op_blocks_d = req_mask;
      op_poff_d   = cmd_program ? buf_poff : '0;
      done_d      = 1'b0;
      lerr_d      = 1'b0;
    end else if (fin) begin
      op_prog_d   = 1'b0;
      op_erase_d  = 1'b0;
      op_blocks_d = '0;
      op_poff_d   = '0;
      done_d      = 1'b1;
    end
    if (refuse)  lerr_d = 1'b1;
    if (buf_clr) oerr_d = 1'b0;
    else if (buf_rej) oerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_prog_q   <= 1'b0;
      op_erase_q  <= 1'b0;
      op_blocks_q <= '0;
      op_poff_q   <= '0;
      done_q      <= 1'b0;
      lerr_q      <= 1'b0;
      oerr_q      <= 1'b0;
    end else begin
      op_prog_q   <= op_prog_d;
      op_erase_q  <= op_erase_d;
      op_blocks_q <= op_blocks_d;
      op_poff_q   <= op_poff_d;
      done_q      <= done_d;
      lerr_q      <= lerr_d;
      oerr_q      <= oerr_d;
    end
  end

  // read gating
  assign arr_rd_en      = bus_valid && !bus_write && !busy;
  assign arr_addr       = bus_addr;
  assign bus_rd_blocked = bus_valid && !bus_write && busy;
  assign bus_rdata      = arr_rd_en ? arr_rdata : '0;

  assign hv_program    = op_prog_q;
  assign hv_erase      = op_erase_q;
  assign hv_blocks     = op_blocks_q;
  assign hv_offset     = op_poff_q;
  assign st_armed      = armed;
  assign st_busy       = busy;
  assign st_done       = done_q;
  assign st_offset_err = oerr_q;
  assign st_lock_err   = lerr_q;

  assert_read_blocked_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_busy |-> !arr_rd_en);

  assert_no_locked_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_busy |-> ((hv_blocks & cfg_lock) == '0));

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(st_done) |-> $fell(st_busy));

  assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hv_program && hv_erase));

  assert_op_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hv_program || hv_erase) |-> st_busy);
endmodule

// File: tb/test_flash_multipage_prog.sv
module test_flash_multipage_prog;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [17:0] bus_addr, arr_addr;
  logic [7:0]  bus_wdata, bus_rdata, arr_rdata, key_data, pb_rd_data;
  logic        bus_rd_blocked, arr_rd_en, key_valid, key_write;
  logic        cmd_program, cmd_erase;
  logic [7:0]  cmd_erase_mask, cfg_lock, hv_blocks;
  logic [15:0] cfg_pulse_len;
  logic [2:0]  pb_rd_blk;
  logic [5:0]  pb_rd_byte;
  logic        hv_program, hv_erase, st_armed, st_busy, st_done, st_offset_err, st_lock_err;
  logic [8:0]  hv_offset;

  always #5 clk = ~clk;

  flash_multipage_prog i_flash_multipage_prog (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd_blocked(bus_rd_blocked),
    .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .key_valid(key_valid), .key_write(key_write), .key_data(key_data),
    .cmd_program(cmd_program), .cmd_erase(cmd_erase), .cmd_erase_mask(cmd_erase_mask),
    .cfg_lock(cfg_lock), .cfg_pulse_len(cfg_pulse_len),
    .pb_rd_blk(pb_rd_blk), .pb_rd_byte(pb_rd_byte), .pb_rd_data(pb_rd_data),
    .hv_program(hv_program), .hv_erase(hv_erase), .hv_blocks(hv_blocks), .hv_offset(hv_offset),
    .st_armed(st_armed), .st_busy(st_busy), .st_done(st_done),
    .st_offset_err(st_offset_err), .st_lock_err(st_lock_err)
  );

  typedef enum int {
    O_BUSY, O_DONE, O_OERR, O_LERR, O_ARMED, O_HVP, O_HVE, O_HVB, O_HVO,
    O_PBD, O_RDEN, O_RDATA, O_RBLK
  } obs_e;

  typedef struct {
    string       req;
    obs_e        sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    ended    = 0;

  function automatic logic [31:0] observe(obs_e s);
    case (s)
      O_BUSY:  return 32'(st_busy);
      O_DONE:  return 32'(st_done);
      O_OERR:  return 32'(st_offset_err);
      O_LERR:  return 32'(st_lock_err);
      O_ARMED: return 32'(st_armed);
      O_HVP:   return 32'(hv_program);
      O_HVE:   return 32'(hv_erase);
      O_HVB:   return 32'(hv_blocks);
      O_HVO:   return 32'(hv_offset);
      O_PBD:   return 32'(pb_rd_data);
      O_RDEN:  return 32'(arr_rd_en);
      O_RDATA: return 32'(bus_rdata);
      default: return 32'(bus_rd_blocked);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = observe(it.sel);
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s %s: actual %0h expected %0h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, obs_e sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [17:0] mk(int blk, int poff, int b);
    return {3'(blk), 9'(poff), 6'(b)};
  endfunction

  task automatic bwrite(int blk, int poff, int b, logic [7:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = mk(blk, poff, b); bus_wdata = d;
    tick();
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic key_rd();
    key_valid = 1; key_write = 0;
    tick();
    key_valid = 0;
  endtask

  task automatic key_wr(logic [7:0] d);
    key_valid = 1; key_write = 1; key_data = d;
    tick();
    key_valid = 0; key_write = 0;
  endtask

  task automatic unlock();
    key_rd(); key_wr(8'h3C); key_wr(8'hC3);
  endtask

  task automatic pb(int blk, int b, logic [7:0] e, string req);
    pb_rd_blk = 3'(blk); pb_rd_byte = 6'(b);
    push(req, O_PBD, 32'(e));
    @(negedge clk); #1;
  endtask

  task automatic flush();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0; arr_rdata = 8'h5A;
    key_valid = 0; key_write = 0; key_data = '0; cmd_program = 0; cmd_erase = 0;
    cmd_erase_mask = '0; cfg_lock = '0; cfg_pulse_len = 16'd5; pb_rd_blk = '0; pb_rd_byte = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    push("R1", O_BUSY, 0); push("R1", O_DONE, 0); push("R1", O_OERR, 0);
    push("R1", O_LERR, 0); push("R1", O_ARMED, 0); push("R1", O_HVP, 0);
    push("R1", O_HVE, 0); push("R1", O_HVB, 0);
    flush();

    // R2 address decode and buffer contents
    tick();
    bwrite(2, 5, 3, 8'h11);
    bwrite(6, 5, 63, 8'h22);
    pb(2, 3, 8'h11, "R2");
    pb(2, 4, 8'hFF, "R2");
    pb(6, 63, 8'h22, "R2");
    pb(0, 0, 8'hFF, "R2");

    // R3 offset mismatch rejected
    tick();
    bwrite(1, 7, 0, 8'h33);
    push("R3", O_OERR, 1); flush();
    pb(1, 0, 8'hFF, "R3");
    tick();
    bwrite(2, 7, 3, 8'h99);
    pb(2, 3, 8'h11, "R3");

    // R4 command without unlock ignored; broken sequence stays disarmed
    tick();
    cmd_program = 1; tick(); cmd_program = 0;
    push("R4", O_BUSY, 0); push("R4", O_ARMED, 0); flush();
    tick();
    key_rd(); key_wr(8'h3C); key_wr(8'h00);
    push("R4", O_ARMED, 0); flush();
    tick();
    unlock();
    push("R4", O_ARMED, 1); flush();

    // R7 program refused by lock on block 6; R12 arming consumed
    tick();
    cfg_lock = 8'h40;
    cmd_program = 1; tick(); cmd_program = 0;
    push("R7", O_LERR, 1); push("R7", O_BUSY, 0); push("R12", O_ARMED, 0); flush();

    // R5 program with erase requested at once (R12 priority), R8 length 5, R9 blocking
    tick();
    cfg_lock = 8'h00; cfg_pulse_len = 16'd5;
    unlock();
    cmd_program = 1; cmd_erase = 1; cmd_erase_mask = 8'h0F; tick();
    cmd_program = 0; cmd_erase = 0;
    push("R5", O_HVP, 1); push("R12", O_HVE, 0); push("R5", O_HVB, 32'h44);
    push("R5", O_HVO, 5); push("R7", O_LERR, 0); push("R12", O_ARMED, 0);
    for (int i = 0; i < 5; i++) begin
      push("R8", O_BUSY, 1);
      if (i == 2) begin
        bus_valid = 1; bus_write = 0; bus_addr = mk(4, 1, 1);
        push("R9", O_RDEN, 0); push("R9", O_RDATA, 0); push("R9", O_RBLK, 1);
      end
      flush();
      bus_valid = 0;
      @(posedge clk); #2;
    end
    push("R8", O_BUSY, 0); push("R8", O_DONE, 1); push("R5", O_HVP, 0); flush();

    // R10 buffer emptied and offset error cleared after program
    pb(2, 3, 8'hFF, "R10");
    push("R10", O_OERR, 0); flush();
    tick();
    bwrite(0, 9, 0, 8'h44);
    push("R10", O_OERR, 0); flush();
    pb(0, 0, 8'h44, "R10");

    // R6 erase with length 0 (R8 one cycle), R11 write during busy dropped
    tick();
    cfg_pulse_len = 16'd0;
    unlock();
    cmd_erase = 1; cmd_erase_mask = 8'h81; tick(); cmd_erase = 0;
    push("R6", O_HVE, 1); push("R6", O_HVB, 32'h81); push("R8", O_BUSY, 1); push("R8", O_DONE, 0);
    bus_valid = 1; bus_write = 1; bus_addr = mk(0, 9, 0); bus_wdata = 8'h77;
    flush();
    @(posedge clk); #2;
    bus_valid = 0; bus_write = 0;
    push("R8", O_BUSY, 0); push("R8", O_DONE, 1); push("R6", O_HVE, 0); flush();
    pb(0, 0, 8'h44, "R11");

    // R9 read passes when idle
    tick();
    bus_valid = 1; bus_write = 0; bus_addr = mk(3, 2, 1);
    push("R9", O_RDEN, 1); push("R9", O_RDATA, 32'h5A); push("R9", O_RBLK, 0);
    flush();
    bus_valid = 0;

    // R7 erase refused by lock on block 0
    tick();
    cfg_lock = 8'h01;
    unlock();
    cmd_erase = 1; cmd_erase_mask = 8'h03; tick(); cmd_erase = 0;
    push("R7", O_LERR, 1); push("R7", O_BUSY, 0); push("R7", O_HVE, 0); flush();

    tick();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule